// File: doc/BRIEF.md
# Serial Character Receiver with Error Flags

This block takes an asynchronous serial line and turns it into bytes that a processor reads over a small register bus. The length of one bit is set in module clock cycles by a 16-bit divider, so the baud rate is the module clock frequency divided by the divider value. Each frame starts with a low start bit and carries eight data bits, least significant first. An optional parity bit follows, then a high stop bit.

Bits are shifted into a shift register. When a frame completes, the character moves into a single holding register and a "data ready" flag is set. If the holding register has not been read when the next frame completes, the new character stays in the shift register and is dropped. The held character is kept, and an overrun flag goes up. A parity mismatch raises a parity flag. Both error flags stay set until software writes a one to their bit.

The bus has four word registers, selected by `bus_addr`:

| `bus_addr` | Register | Contents |
|---|---|---|
| 0 | data | Received character in bits 7:0. Reading it clears the ready flag. |
| 1 | status | Bit 0 ready, bit 1 overrun, bit 2 parity error. |
| 2 | divider | Bit period in clock cycles. |
| 3 | control | Bit 0 parity enable, bit 1 odd parity. |

Top module: `uart_rx_core`

## Requirements
- R1: After reset the divider reads 16, and the status, control and data registers all read 0.
- R2: A write to the divider (`bus_addr`=2) stores `bus_wdata[15:0]`. A value below 16 is stored as 16. Bits 31:16 of the divider always read 0.
- R3: One bit lasts exactly divider-value clock cycles. A frame begins on a high-to-low transition of `rxd`. The start bit is checked at half a bit period, and each later bit is sampled at the centre of its period. Data bits arrive least significant bit first.
- R4: A low pulse on `rxd` that is shorter than half a bit period does not start a character, so the ready flag stays 0.
- R5: A completed character is moved into the data register when that register is empty. This sets status bit 0. Reading `bus_addr`=0 returns the character in bits 7:0 and clears status bit 0.
- R6: With control bit 0 set, one parity bit follows the data. Control bit 1 selects odd parity when 1 and even parity when 0. A parity bit that does not match sets status bit 2.
- R7: A character that completes while status bit 0 is still set raises status bit 1, the overrun flag. The held character is left unchanged.
- R8: Writing 1 to status bit 1 or bit 2 clears that flag. Writing 0 leaves the flag as it is.
- R9: With control bit 0 clear, the frame has no parity bit, and status bit 2 is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |

## Verification
The characters 0xA5, 0x3C, 0x81 and 0x5A are received in several forms:
- **No parity, divider 16 and divider 40.** This separates a correct bit period from an off-by-one count and a reversed bit order.
- **Even and odd parity, correct and corrupted parity bit.** This shows that the parity flag follows both the sense setting and the line.
- **Three back-to-back characters with no read in between.** This separates "keep the first character" from "overwrite with the latest".
- **A short low glitch.** This separates the half-period start check from a plain edge trigger.
- **Zero writes and one writes to the flags.** These separate write-one-to-clear from write-any-to-clear.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int DIV_W   = 16;
    localparam int DIV_MIN = 16;
    localparam int BUS_W   = 32;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_STAT = 2'd1,
        REG_DIV  = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_e;

    typedef struct packed {
        logic par_odd;
        logic par_en;
    } rx_cfg_t;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] v);
        return (v < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : v;
    endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_s,
    input  logic [DIV_W-1:0] div_q,
    input  rx_cfg_t          cfg,
    output logic             done,
    output logic [DW-1:0]    char_o,
    output logic             perr_o
);
    localparam int IDX_W = (DW > 1) ? $clog2(DW) : 1;

    rx_state_e        state_q;
    logic [DIV_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    shift_q;
    logic             prev_q;
    logic             perr_q;
    logic             tick;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            prev_q  <= 1'b1;
            perr_q  <= 1'b0;
            done    <= 1'b0;
        end else begin
            prev_q <= rx_s;
            done   <= 1'b0;
            if (state_q != S_IDLE && !tick) cnt_q <= cnt_q - 1'b1;
            case (state_q)
                S_IDLE: begin
                    if (prev_q && !rx_s) begin
                        state_q <= S_START;
                        cnt_q   <= (div_q >> 1) - 1'b1;
                    end
                end
                S_START: if (tick) begin
                    if (!rx_s) begin
                        state_q <= S_DATA;
                        cnt_q   <= div_q - 1'b1;
                        idx_q   <= '0;
                        perr_q  <= 1'b0;
                    end else begin
                        state_q <= S_IDLE;
                    end
                end
                S_DATA: if (tick) begin
                    shift_q <= {rx_s, shift_q[DW-1:1]};
                    cnt_q   <= div_q - 1'b1;
                    idx_q   <= idx_q + 1'b1;
                    if (idx_q == IDX_W'(DW-1))
                        state_q <= cfg.par_en ? S_PAR : S_STOP;
                end
                S_PAR: if (tick) begin
                    perr_q  <= ((^shift_q) ^ rx_s) != cfg.par_odd;
                    cnt_q   <= div_q - 1'b1;
                    state_q <= S_STOP;
                end
                S_STOP: if (tick) begin
                    done    <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign char_o = shift_q;
    assign perr_o = perr_q;
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
    import uart_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_div,
    input  logic             wr_ctrl,
    input  logic             wr_stat,
    input  logic             rd_data,
    input  logic [DIV_W-1:0] wdata,
    input  logic             done,
    input  logic [DW-1:0]    char_i,
    input  logic             perr_i,
    output logic [DIV_W-1:0] div_q,
    output rx_cfg_t          cfg_q,
    output logic             full_q,
    output logic             ovr_q,
    output logic             perr_q,
    output logic [DW-1:0]    data_q
);
    logic take;

    // A read in the same cycle frees the holding register for the new character.
    assign take = done && (!full_q || rd_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= DIV_W'(DIV_MIN);
            cfg_q  <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            perr_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (wr_div)  div_q <= clamp_div(wdata);
            if (wr_ctrl) cfg_q <= rx_cfg_t'(wdata[1:0]);

            if (take) begin
                data_q <= char_i;
                full_q <= 1'b1;
            end else if (rd_data) begin
                full_q <= 1'b0;
            end

            if (done && !take)            ovr_q <= 1'b1;
            else if (wr_stat && wdata[1]) ovr_q <= 1'b0;

            if (done && perr_i)           perr_q <= 1'b1;
            else if (wr_stat && wdata[2]) perr_q <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata
);
    logic             rx_s;
    logic             rx_done;
    logic [DW-1:0]    rx_char;
    logic             rx_perr;
    logic [DIV_W-1:0] div_q;
    rx_cfg_t          cfg_q;
    logic             full_q;
    logic             ovr_q;
    logic             perr_q;
    logic [DW-1:0]    data_q;
    logic             wr_div;
    logic             wr_ctrl;
    logic             wr_stat;
    logic             rd_data;
    reg_sel_e         sel;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_div  = bus_sel &&  bus_we && sel == REG_DIV;
    assign wr_ctrl = bus_sel &&  bus_we && sel == REG_CTRL;
    assign wr_stat = bus_sel &&  bus_we && sel == REG_STAT;
    assign rd_data = bus_sel && !bus_we && sel == REG_DATA;

    uart_rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(rx_s)
    );

    uart_rx_sampler #(.DW(DW)) u_smp (
        .clk(clk), .rst(rst), .rx_s(rx_s), .div_q(div_q), .cfg(cfg_q),
        .done(rx_done), .char_o(rx_char), .perr_o(rx_perr)
    );

    uart_rx_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_div(wr_div), .wr_ctrl(wr_ctrl),
        .wr_stat(wr_stat), .rd_data(rd_data), .wdata(bus_wdata[DIV_W-1:0]),
        .done(rx_done), .char_i(rx_char), .perr_i(rx_perr),
        .div_q(div_q), .cfg_q(cfg_q), .full_q(full_q), .ovr_q(ovr_q),
        .perr_q(perr_q), .data_q(data_q)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            REG_DATA: bus_rdata[DW-1:0]    = data_q;
            REG_STAT: bus_rdata[2:0]       = {perr_q, ovr_q, full_q};
            REG_DIV:  bus_rdata[DIV_W-1:0] = div_q;
            REG_CTRL: bus_rdata[1:0]       = cfg_q;
            default:  bus_rdata            = '0;
        endcase
    end
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk
    import uart_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_done,
    input logic             rd_data,
    input logic             wr_stat,
    input logic [1:0]       clr_bits,
    input logic             full_q,
    input logic             ovr_q,
    input logic             perr_q,
    input logic [DW-1:0]    data_q,
    input logic [DIV_W-1:0] div_q
);
    p_div_floor_r2: assert property (@(posedge clk) disable iff (rst)
        div_q >= DIV_W'(DIV_MIN));

    p_ovr_keeps_data_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_done && full_q && !rd_data) |=> (ovr_q && data_q == $past(data_q)));

    p_ovr_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> $past(rx_done && full_q && !rd_data));

    p_read_frees_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !rx_done) |=> !full_q);

    p_ovr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!rx_done && !(wr_stat && clr_bits[0])) |=> ovr_q == $past(ovr_q));

    p_perr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!rx_done && !(wr_stat && clr_bits[1])) |=> perr_q == $past(perr_q));
endmodule

bind uart_rx_core uart_rx_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rd_data(rd_data),
    .wr_stat(wr_stat), .clr_bits(bus_wdata[2:1]), .full_q(full_q),
    .ovr_q(ovr_q), .perr_q(perr_q), .data_q(data_q), .div_q(div_q)
);

// File: tb/uart_rx_core_test.sv
module uart_rx_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int divv  = 16;
    bit odd   = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_core uut (
        .clk(clk), .rst(rst), .rxd(rxd), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // pmode: 0 = no parity bit, 1 = correct parity bit, 2 = wrong parity bit
    task automatic send(input logic [7:0] c, input int pmode);
        logic [10:0] bits;
        int nb;
        logic pb;
        pb = (^c) ^ odd;
        if (pmode == 2) pb = ~pb;
        if (pmode == 0) begin bits = {1'b0, 1'b1, c, 1'b0}; nb = 10; end
        else            begin bits = {1'b1, pb, c, 1'b0};   nb = 11; end
        @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = bits[i];
            repeat (divv) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2, d); check("R1 divider", d, 32'd16);
        rd(1, d); check("R1 status",  d, 32'd0);
        rd(3, d); check("R1 control", d, 32'd0);
        rd(0, d); check("R1 data",    d, 32'd0);
    endtask

    task automatic t_divider;
        logic [31:0] d;
        wr(2, 32'd5);       rd(2, d); check("R2 clamp below floor", d, 32'd16);
        wr(2, 32'h0001_2345); rd(2, d); check("R2 upper bits", d, 32'h2345);
        wr(2, 32'd16);      rd(2, d); check("R2 restore", d, 32'd16);
    endtask

    task automatic t_plain;
        logic [31:0] d;
        send(8'hA5, 0);
        rd(1, d); check("R5 ready set", d, 32'h1);
        rd(0, d); check("R3 R9 char 0xA5", d, 32'hA5);
        rd(1, d); check("R5 ready cleared by read", d, 32'h0);
        divv = 40; wr(2, 32'd40);
        send(8'h3C, 0);
        rd(0, d); check("R3 divider 40 char", d, 32'h3C);
        divv = 16; wr(2, 32'd16);
    endtask

    task automatic t_glitch;
        logic [31:0] d;
        @(negedge clk); rxd = 1'b0;
        repeat (3) @(negedge clk); rxd = 1'b1;
        repeat (40) @(negedge clk);
        rd(1, d); check("R4 glitch rejected", d, 32'h0);
    endtask

    task automatic t_parity;
        logic [31:0] d;
        odd = 1'b0; wr(3, 32'h1);
        send(8'h81, 1);
        rd(1, d); check("R6 even good", d, 32'h1);
        rd(0, d); check("R6 even good char", d, 32'h81);
        send(8'h81, 2);
        rd(1, d); check("R6 even bad", d, 32'h5);
        rd(0, d);
        wr(1, 32'h0); rd(1, d); check("R8 zero write keeps parity flag", d, 32'h4);
        wr(1, 32'h4); rd(1, d); check("R8 one write clears parity flag", d, 32'h0);
        odd = 1'b1; wr(3, 32'h3);
        send(8'h5A, 1);
        rd(1, d); check("R6 odd good", d, 32'h1);
        rd(0, d);
        send(8'h5A, 2);
        rd(1, d); check("R6 odd bad", d, 32'h5);
        rd(0, d); wr(1, 32'h4);
        odd = 1'b0; wr(3, 32'h0);
        send(8'hFE, 0);
        rd(1, d); check("R9 no parity flag when disabled", d, 32'h1);
        rd(0, d); check("R9 char", d, 32'hFE);
    endtask

    task automatic t_overrun;
        logic [31:0] d;
        send(8'h11, 0);
        send(8'h22, 0);
        rd(1, d); check("R7 overrun flag", d, 32'h3);
        send(8'h33, 0);
        rd(0, d); check("R7 first char kept", d, 32'h11);
        rd(1, d); check("R5 R7 ready clear, overrun kept", d, 32'h2);
        wr(1, 32'h0); rd(1, d); check("R8 zero write keeps overrun", d, 32'h2);
        wr(1, 32'h2); rd(1, d); check("R8 one write clears overrun", d, 32'h0);
        send(8'h44, 0);
        rd(0, d); check("R5 transfer after overrun", d, 32'h44);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_divider();
        t_plain();
        t_glitch();
        t_parity();
        t_overrun();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule